// File: doc/BRIEF.md
# Attribute Change Delay Line

This block sits between the video register file and the pixel shifter of a character-based display generator. It runs on the fast clock of the video section, which is 28.636363 MHz (twice 14.318181 MHz). At that rate one pixel lasts 7 fast ticks and one processor cycle lasts 28. Each register field reaches the shifter after its own latency, and that latency is finer than one pixel.

Two paths are provided. The reverse-video bit passes through a 12-stage shift chain. A tap select port picks how many fast ticks it waits, and the usual setting is tap 11, which gives 12 ticks. The colour bits get a fixed 7-stage chain, which is one pixel. A holding register then hands the colour to the shifter only on a pixel-phase strobe, so the colour always changes on a pixel boundary. Only the reverse bit uses the long tunable chain.

While reset is asserted, and on the first clock after it, the outputs pass the live register values straight through. At that first clock every stage is filled with the live values, so releasing reset causes no false transition.

Top module: `attr_delay_line`

## Requirements
- R1: While rst_n is low, rev_q equals rev_in and colour_q equals colour_in, combinationally.
- R2: With rev_tap = 11, a value of rev_in sampled at a fast-clock edge appears on rev_q 12 edges later. In general, tap k gives k+1 edges.
- R3: rev_tap can be changed at run time. Every tap from 0 to 11 selects a delay of tap+1 edges, and the change takes effect at once on rev_q.
- R4: A rev_tap value above 11 (12 to 15) acts exactly like tap 11.
- R5: colour_q changes only at a clock edge where pix_stb is high. At that edge it takes the colour_in value sampled 7 edges earlier. At every other edge colour_q holds.
- R6: At the first clock edge after reset release, every stage loads the current inputs. From then on the outputs equal those values until later input changes have run through the chains, so no transition appears that the inputs did not make.
- R7: The two paths are independent. Changes on rev_in or rev_tap never move colour_q, and changes on colour_in or pix_stb never move rev_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast video clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rev_in | input | 1 | Reverse-video bit as currently held in the register |
| colour_in | input | COL_W (8) | Colour register bits as currently held |
| pix_stb | input | 1 | High on the fast tick at which the shifter takes a new pixel |
| rev_tap | input | 4 | Tap select for the reverse chain (0 to 11; larger values clamp to 11) |
| rev_q | output | 1 | Delayed reverse bit for the pixel shifter |
| colour_q | output | COL_W (8) | Delayed, pixel-aligned colour for the pixel shifter |

## Verification
The properties assume that reset is released in step with the clock, and that rev_in, colour_in, pix_stb and rev_tap change only away from the rising edge. The bench meets this by driving every input on the falling edge. The hold property also assumes that pix_stb is a single-tick pulse in step with the clock; nothing in the properties depends on it having a fixed period. The stimulus therefore uses a regular 7-tick strobe, a fast 3-tick strobe and a long gap with no strobe. The tap-zero property assumes rev_tap is steady over the sampled edge, which holds because taps are changed only on falling edges.

// File: rtl/attr_delay_pkg.sv
package attr_delay_pkg;
  // Stage counts for the two attribute paths, in fast-clock ticks.
  localparam int unsigned REV_STAGES_DEF = 12;
  localparam int unsigned COL_STAGES_DEF = 7;
  localparam int unsigned COL_W_DEF      = 8;

  // Width of a selector that can address every stage of a chain.
  function automatic int unsigned sel_width(input int unsigned depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/attr_stage_chain.sv
module attr_stage_chain #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               load_all,
  input  logic [W-1:0]       din,
  output logic [DEPTH*W-1:0] taps
);
  logic [DEPTH-1:0][W-1:0] st_q;
  logic [DEPTH-1:0][W-1:0] st_d;

  // Next state: a normal shift, or a broadside fill from din when priming.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (load_all || i == 0) st_d[i] = din;
      else                    st_d[i] = st_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st_q <= '0;
    else if (en) st_q <= st_d;
  end

  assign taps = st_q;
endmodule

// File: rtl/attr_tap_pick.sv
module attr_tap_pick #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned SEL_W = 4
) (
  input  logic [DEPTH-1:0] taps,
  input  logic [SEL_W-1:0] sel,
  output logic             pick
);
  localparam int unsigned LAST = DEPTH - 1;

  generate
    if (DEPTH == 1) begin : g_single
      assign pick = taps[0];
    end else begin : g_mux
      logic [SEL_W-1:0] sel_c;
      // Out-of-range selections saturate at the deepest stage.
      assign sel_c = (32'(sel) > LAST) ? SEL_W'(LAST) : sel;
      assign pick  = taps[sel_c];
    end
  endgenerate
endmodule

// File: rtl/attr_prime_ctl.sv
module attr_prime_ctl (
  input  logic clk,
  input  logic rst_n,
  output logic primed
);
  logic primed_d;

  always_comb primed_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= primed_d;
  end
endmodule

// File: rtl/attr_delay_line.sv
module attr_delay_line
  import attr_delay_pkg::*;
#(
  parameter int unsigned COL_W      = COL_W_DEF,
  parameter int unsigned REV_STAGES = REV_STAGES_DEF,
  parameter int unsigned COL_STAGES = COL_STAGES_DEF,
  parameter int unsigned TAP_W      = sel_width(REV_STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rev_in,
  input  logic [COL_W-1:0] colour_in,
  input  logic             pix_stb,
  input  logic [TAP_W-1:0] rev_tap,
  output logic             rev_q,
  output logic [COL_W-1:0] colour_q
);
  localparam int unsigned COL_LAST = COL_STAGES - 1;

  logic                        primed;
  logic                        load_all;
  logic                        chain_en;
  logic [REV_STAGES-1:0]       rev_taps;
  logic                        rev_pick;
  logic [COL_STAGES*COL_W-1:0] col_taps;
  logic [COL_W-1:0]            col_tail;
  logic [COL_W-1:0]            col_hold_q;
  logic [COL_W-1:0]            col_hold_d;

  assign chain_en = 1'b1;
  assign load_all = ~primed;

  attr_prime_ctl u_prime (
    .clk    (clk),
    .rst_n  (rst_n),
    .primed (primed)
  );

  attr_stage_chain #(.W(1), .DEPTH(REV_STAGES)) u_rev_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (chain_en),
    .load_all (load_all),
    .din      (rev_in),
    .taps     (rev_taps)
  );

  attr_tap_pick #(.DEPTH(REV_STAGES), .SEL_W(TAP_W)) u_rev_pick (
    .taps (rev_taps),
    .sel  (rev_tap),
    .pick (rev_pick)
  );

  attr_stage_chain #(.W(COL_W), .DEPTH(COL_STAGES)) u_col_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (chain_en),
    .load_all (load_all),
    .din      (colour_in),
    .taps     (col_taps)
  );

  assign col_tail = col_taps[COL_LAST*COL_W +: COL_W];

  // Pixel-aligned colour holding register.
  always_comb begin
    if (load_all)     col_hold_d = colour_in;
    else if (pix_stb) col_hold_d = col_tail;
    else              col_hold_d = col_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_hold_q <= '0;
    else        col_hold_q <= col_hold_d;
  end

  // Pass the live values through until the chains hold valid data.
  assign rev_q    = primed ? rev_pick   : rev_in;
  assign colour_q = primed ? col_hold_q : colour_in;
endmodule

// File: rtl/attr_delay_line_chk.sv
module attr_delay_line_chk #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned TAP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rev_in,
  input logic [COL_W-1:0] colour_in,
  input logic             pix_stb,
  input logic [TAP_W-1:0] rev_tap,
  input logic             rev_q,
  input logic [COL_W-1:0] colour_q,
  input logic             primed
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_bypass_chk: assert (rev_q == rev_in && colour_q == colour_in);
    end
  end

  // R3
  tap_zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(primed) && rev_tap == '0 |-> rev_q == $past(rev_in));

  // R5
  colour_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(primed) && !$past(pix_stb) |-> $stable(colour_q));

  // R6
  prime_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed) |-> (rev_q == $past(rev_in) && colour_q == $past(colour_in)));

  // R6
  prime_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(primed) |-> primed);
endmodule

bind attr_delay_line attr_delay_line_chk #(.COL_W(COL_W), .TAP_W(TAP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rev_in    (rev_in),
  .colour_in (colour_in),
  .pix_stb   (pix_stb),
  .rev_tap   (rev_tap),
  .rev_q     (rev_q),
  .colour_q  (colour_q),
  .primed    (primed)
);

// File: tb/attr_delay_line_bench.sv
`timescale 1ns/1ps
module attr_delay_line_bench;
  localparam int COL_W = 8;
  localparam int TAP_W = 4;
  localparam int HMAX  = 2048;

  typedef struct {
    logic             rev;
    logic [COL_W-1:0] col;
    string            rev_tag;
    string            col_tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rev_in = 1'b0;
  logic [COL_W-1:0] colour_in = '0;
  logic             pix_stb = 1'b0;
  logic [TAP_W-1:0] rev_tap = 4'd11;
  logic             rev_q;
  logic [COL_W-1:0] colour_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t             sb_q[$];
  logic             rev_h[HMAX];
  logic [COL_W-1:0] col_h[HMAX];
  logic [COL_W-1:0] col_model;
  int               k = 0;
  string            cur_rev_tag = "R6";
  string            cur_col_tag = "R6";

  always #10 clk = ~clk;

  attr_delay_line #(.COL_W(COL_W)) u_attr_delay_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .rev_in    (rev_in),
    .colour_in (colour_in),
    .pix_stb   (pix_stb),
    .rev_tap   (rev_tap),
    .rev_q     (rev_q),
    .colour_q  (colour_q)
  );

  function automatic int clamp_tap(input int t);
    return (t > 11) ? 11 : t;
  endfunction

  // Driver: applies one cycle of stimulus on the falling edge and queues
  // the outputs expected just after the next rising edge.
  task automatic step(input logic r, input logic [COL_W-1:0] c,
                      input logic s, input int tap);
    exp_t e;
    int   ri;
    int   ci;
    @(negedge clk);
    rev_in    = r;
    colour_in = c;
    pix_stb   = s;
    rev_tap   = TAP_W'(tap);
    k++;
    rev_h[k] = r;
    col_h[k] = c;
    ri = k - (clamp_tap(tap) + 1) + 1;
    if (ri < 1) ri = 1;
    ci = k - 7;
    if (ci < 1) ci = 1;
    if (k == 1)  col_model = c;
    else if (s)  col_model = col_h[ci];
    e.rev     = rev_h[ri];
    e.col     = col_model;
    e.rev_tag = cur_rev_tag;
    e.col_tag = cur_col_tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rev_q !== e.rev) begin
          errors++;
          $display("FAIL %s: rev_q=%0b expected %0b (cycle %0d)", e.rev_tag, rev_q, e.rev, k);
        end
        checks++;
        if (colour_q !== e.col) begin
          errors++;
          $display("FAIL %s: colour_q=%02h expected %02h (cycle %0d)", e.col_tag, colour_q, e.col, k);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic r;
    logic [COL_W-1:0] c;
    int ph;
    // R1: pass-through while reset is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rev_in    = i[0];
      colour_in = 8'h3C + 8'(i * 17);
      #1;
      checks++;
      if (rev_q !== rev_in || colour_q !== colour_in) begin
        errors++;
        $display("FAIL R1: rev_q=%0b colour_q=%02h expected %0b %02h",
                 rev_q, colour_q, rev_in, colour_in);
      end
    end
    @(negedge clk);
    rev_in = 1'b1; colour_in = 8'hA5;
    rst_n  = 1'b1;
    #1;
    checks++;
    if (rev_q !== 1'b1 || colour_q !== 8'hA5) begin
      errors++;
      $display("FAIL R6: rev_q=%0b colour_q=%02h expected 1 a5 before first edge", rev_q, colour_q);
    end
    // R6: steady inputs after release, no transition
    cur_rev_tag = "R6"; cur_col_tag = "R6";
    for (int i = 0; i < 16; i++) step(1'b1, 8'hA5, (i % 7) == 6, 11);
    // R2 / R5: default tap, regular pixel strobe
    cur_rev_tag = "R2"; cur_col_tag = "R5";
    ph = 0;
    for (int i = 0; i < 120; i++) begin
      r = (i % 5 < 2) ^ $urandom_range(0, 1) == 1;
      c = (i % 9 == 0) ? 8'($urandom) : colour_in;
      step(r, c, (ph % 7) == 6, 11);
      ph++;
    end
    // R3: several taps, changed at run time
    cur_rev_tag = "R3";
    for (int t = 0; t < 12; t += 3) begin
      for (int i = 0; i < 30; i++) step($urandom_range(0, 1) == 1, colour_in, (i % 7) == 3, t);
    end
    for (int i = 0; i < 40; i++) step($urandom_range(0, 1) == 1, colour_in, 1'b0, i % 12);
    // R4: taps past the end clamp to the last stage
    cur_rev_tag = "R4";
    for (int t = 12; t < 16; t++) begin
      for (int i = 0; i < 25; i++) step($urandom_range(0, 1) == 1, colour_in, (i % 7) == 0, t);
    end
    // R5: fast strobe, then a long gap without strobe
    cur_rev_tag = "R2";
    cur_col_tag = "R5";
    for (int i = 0; i < 40; i++) step(rev_in, 8'($urandom), (i % 3) == 2, 11);
    for (int i = 0; i < 30; i++) step(rev_in, 8'($urandom), 1'b0, 11);
    for (int i = 0; i < 20; i++) step(rev_in, colour_in, (i % 7) == 1, 11);
    // R7: reverse activity with colour steady, then colour activity with reverse steady
    cur_rev_tag = "R7"; cur_col_tag = "R7";
    for (int i = 0; i < 40; i++) step($urandom_range(0, 1) == 1, 8'h5A, (i % 7) == 4, i % 16);
    for (int i = 0; i < 40; i++) step(1'b0, 8'($urandom), $urandom_range(0, 1) == 1, 5);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule